// File: doc/BRIEF.md
# GCM Authentication Tag Finisher

This block performs the last step of GCM authentication. It takes the final GHASH value and the encrypted initial counter block, and XORs them to form the 128-bit authentication tag. A programmable ICV size then truncates the tag. Sizes of 8 and 12 bytes keep that many leading bytes. Every other code yields the full 16-byte tag.

On an outbound operation the block presents the truncated tag. On an inbound operation it also compares the truncated tag with a received tag and raises an authentication-failure flag if they differ. The comparison covers only the effective bytes of the tag.

One pulse on `start_i` captures all inputs on that clock edge. One cycle later the result appears with `tag_valid_o`.

The control is a two-state machine:
- `S_IDLE`: no result is being presented.
- `S_EMIT`: `tag_valid_o` is high and the captured result is on the outputs.

Its transitions are:
- `go` (S_IDLE to S_EMIT): taken on `start_i`.
- `again` (S_EMIT to S_EMIT): taken on a back-to-back `start_i`.
- `done` (S_EMIT to S_IDLE): taken when `start_i` is low.
- `wait` (S_IDLE to S_IDLE): taken when `start_i` is low.

The tag register holds its value between operations.

Top module: `gcm_tag_finish`

## Requirements
- R1: After reset `tag_valid_o` and `auth_fail_o` are 0 and `tag_o` is all zeros.
- R2: With an ICV size code of 16, `tag_o` equals `ghash_i XOR ctr0_enc_i` as sampled at the start edge. Byte 0, the first transmitted byte, is bits [127:120].
- R3: With an ICV size code of 8, `tag_o[127:64]` carries the first 8 tag bytes and `tag_o[63:0]` is zero.
- R4: With an ICV size code of 12, `tag_o[127:32]` carries the first 12 tag bytes and `tag_o[31:0]` is zero.
- R5: Every 5-bit size code other than 8 and 12 (including 0, 1, 9 and 17 to 31) gives the full 16-byte tag.
- R6: `tag_valid_o` is high in exactly the cycle after each cycle in which `start_i` is sampled high, so back-to-back starts keep it high.
- R7: On an inbound operation (`inbound_i`=1), `auth_fail_o` is 1 alongside `tag_valid_o` when any effective byte of `rx_tag_i` differs from the formed tag. Otherwise it is 0.
- R8: Bytes of `rx_tag_i` outside the effective length (bits [63:0] for size 8, bits [31:0] for size 12) do not affect `auth_fail_o`.
- R9: On an outbound operation (`inbound_i`=0), `auth_fail_o` stays 0 whatever `rx_tag_i` holds.
- R10: `tag_o` keeps the last result until the next start. Input changes without `start_i` leave it and `tag_valid_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture strobe for one operation |
| inbound_i | input | 1 | 1 = inbound (check tag), 0 = outbound |
| icv_size_i | input | 5 | ICV size code in bytes |
| ghash_i | input | 128 | Final GHASH value |
| ctr0_enc_i | input | 128 | Encrypted initial counter block |
| rx_tag_i | input | 128 | Received tag, first byte in bits [127:120] |
| tag_o | output | 128 | Truncated tag, dropped bytes zero |
| tag_valid_o | output | 1 | Result valid, one cycle per start |
| auth_fail_o | output | 1 | Inbound tag mismatch |

## Verification
The hardest situation to bring about is a received tag that is wrong only in bytes that truncation discards. In that case the failure flag must stay low, although a full-width comparison would raise it. The stimulus table builds each received tag from the expected tag. It then flips a chosen byte just inside or just outside the effective length, and can fill the discarded tail with junk. This separates correct masking from an off-by-one in the mask at both the 8-byte and 12-byte boundaries. Back-to-back starts and input changes between starts are driven directly to expose capture and hold errors.

// File: rtl/gtf_pkg.sv
package gtf_pkg;
    localparam int TAG_BYTES_D = 16;
    localparam int SIZE_W_D    = 5;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } gtf_state_e;
endpackage

// File: rtl/gtf_size_decode.sv
module gtf_size_decode #(
    parameter int TAG_BYTES = 16,
    parameter int SIZE_W    = 5,
    parameter int SHORT_A   = 8,
    parameter int SHORT_B   = 12
) (
    input  logic [SIZE_W-1:0]    size_i,
    output logic [TAG_BYTES-1:0] keep_o
);
    localparam int LEN_W = $clog2(TAG_BYTES + 1);
    localparam logic [SIZE_W-1:0] CODE_A = SIZE_W'(SHORT_A);
    localparam logic [SIZE_W-1:0] CODE_B = SIZE_W'(SHORT_B);

    logic [LEN_W-1:0] eff_len;

    // Only the two short codes truncate; every other code selects the full tag.
    always_comb begin
        if (size_i == CODE_A)
            eff_len = LEN_W'(SHORT_A);
        else if (size_i == CODE_B)
            eff_len = LEN_W'(SHORT_B);
        else
            eff_len = LEN_W'(TAG_BYTES);
    end

    // Lane j covers bits [8j+7:8j]; lanes are ranked from the top (first sent).
    for (genvar j = 0; j < TAG_BYTES; j++) begin : g_lane
        localparam logic [LEN_W-1:0] RANK = LEN_W'(TAG_BYTES - j);
        assign keep_o[j] = (eff_len >= RANK);
    end
endmodule

// File: rtl/gtf_tag_former.sv
module gtf_tag_former #(
    parameter int TAG_BYTES = 16
) (
    input  logic [TAG_BYTES*8-1:0] ghash_i,
    input  logic [TAG_BYTES*8-1:0] ctr0_enc_i,
    input  logic [TAG_BYTES-1:0]   keep_i,
    output logic [TAG_BYTES*8-1:0] tag_o
);
    for (genvar j = 0; j < TAG_BYTES; j++) begin : g_lane
        assign tag_o[8*j +: 8] = keep_i[j] ? (ghash_i[8*j +: 8] ^ ctr0_enc_i[8*j +: 8])
                                           : 8'h00;
    end
endmodule

// File: rtl/gtf_compare.sv
module gtf_compare #(
    parameter int TAG_BYTES = 16
) (
    input  logic [TAG_BYTES*8-1:0] tag_i,
    input  logic [TAG_BYTES*8-1:0] rx_i,
    input  logic [TAG_BYTES-1:0]   keep_i,
    output logic                   mismatch_o
);
    logic [TAG_BYTES-1:0] lane_bad;

    for (genvar j = 0; j < TAG_BYTES; j++) begin : g_lane
        assign lane_bad[j] = keep_i[j] && (tag_i[8*j +: 8] != rx_i[8*j +: 8]);
    end

    assign mismatch_o = |lane_bad;
endmodule

// File: rtl/gcm_tag_finish.sv
module gcm_tag_finish
    import gtf_pkg::*;
#(
    parameter int TAG_BYTES = TAG_BYTES_D,
    parameter int SIZE_W    = SIZE_W_D,
    parameter int SHORT_A   = 8,
    parameter int SHORT_B   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   inbound_i,
    input  logic [SIZE_W-1:0]      icv_size_i,
    input  logic [TAG_BYTES*8-1:0] ghash_i,
    input  logic [TAG_BYTES*8-1:0] ctr0_enc_i,
    input  logic [TAG_BYTES*8-1:0] rx_tag_i,
    output logic [TAG_BYTES*8-1:0] tag_o,
    output logic                   tag_valid_o,
    output logic                   auth_fail_o
);
    localparam int TAG_W = TAG_BYTES * 8;
    localparam int KEEP_A_BITS = (TAG_BYTES - SHORT_A) * 8;
    localparam int KEEP_B_BITS = (TAG_BYTES - SHORT_B) * 8;
    localparam logic [SIZE_W-1:0] CODE_A = SIZE_W'(SHORT_A);
    localparam logic [SIZE_W-1:0] CODE_B = SIZE_W'(SHORT_B);

    gtf_state_e state_q, state_d;

    logic [TAG_BYTES-1:0] keep;
    logic [TAG_W-1:0]     tag_d, tag_q;
    logic                 mismatch;
    logic                 fail_q;

    gtf_size_decode #(
        .TAG_BYTES(TAG_BYTES), .SIZE_W(SIZE_W),
        .SHORT_A(SHORT_A), .SHORT_B(SHORT_B)
    ) u_decode (
        .size_i (icv_size_i),
        .keep_o (keep)
    );

    gtf_tag_former #(.TAG_BYTES(TAG_BYTES)) u_former (
        .ghash_i    (ghash_i),
        .ctr0_enc_i (ctr0_enc_i),
        .keep_i     (keep),
        .tag_o      (tag_d)
    );

    gtf_compare #(.TAG_BYTES(TAG_BYTES)) u_cmp (
        .tag_i      (tag_d),
        .rx_i       (rx_tag_i),
        .keep_i     (keep),
        .mismatch_o (mismatch)
    );

    // Next-state selection: go, again, done, wait.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = start_i ? S_EMIT : S_IDLE;
            S_EMIT: state_d = start_i ? S_EMIT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Result capture on the start edge; held otherwise.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            fail_q <= 1'b0;
        end else if (start_i) begin
            tag_q  <= tag_d;
            fail_q <= inbound_i && mismatch;
        end
    end

    // Outputs.
    always_comb begin
        tag_o       = tag_q;
        tag_valid_o = 1'b0;
        auth_fail_o = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_EMIT: begin
                tag_valid_o = 1'b1;
                auth_fail_o = fail_q;
            end
            default: ;
        endcase
    end

    // Assertions
    p_valid_follows_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> tag_valid_o);
    p_valid_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !tag_valid_o);
    p_fail_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        auth_fail_o |-> tag_valid_o);
    p_no_fail_outbound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !inbound_i) |=> !auth_fail_o);
    p_short_a_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && icv_size_i == CODE_A) |=> (tag_o[KEEP_A_BITS-1:0] == '0));
    p_short_b_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && icv_size_i == CODE_B) |=> (tag_o[KEEP_B_BITS-1:0] == '0));
    p_full_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && icv_size_i != CODE_A && icv_size_i != CODE_B)
            |=> (tag_o == $past(ghash_i ^ ctr0_enc_i)));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(tag_o));
endmodule

// File: tb/tb_gcm_tag_finish.sv
module tb_gcm_tag_finish;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         inbound_i = 1'b0;
    logic [4:0]   icv_size_i = '0;
    logic [127:0] ghash_i = '0;
    logic [127:0] ctr0_enc_i = '0;
    logic [127:0] rx_tag_i = '0;
    logic [127:0] tag_o;
    logic         tag_valid_o;
    logic         auth_fail_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gcm_tag_finish dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .inbound_i(inbound_i),
        .icv_size_i(icv_size_i), .ghash_i(ghash_i), .ctr0_enc_i(ctr0_enc_i),
        .rx_tag_i(rx_tag_i), .tag_o(tag_o), .tag_valid_o(tag_valid_o),
        .auth_fail_o(auth_fail_o)
    );

    typedef struct packed {
        logic [4:0]   size;
        logic         inb;
        logic [127:0] g;
        logic [127:0] c;
        logic [7:0]   flip;   // byte index from the top to corrupt; 255 = none
        logic         junk;   // fill dropped bytes of rx with junk
    } vec_t;

    localparam logic [127:0] G1 = 128'h0123456789abcdef_fedcba9876543210;
    localparam logic [127:0] C1 = 128'h66e94bd4ef8a2c3b_884cfa59ca342b2e;
    localparam logic [127:0] G2 = 128'h58e2fccefa7e3061_367f1d57a4e7455a;
    localparam logic [127:0] C2 = 128'h0388dace60b6a392_f328c2b971b2fe78;
    localparam logic [127:0] G3 = {4{32'hdeadbeef}};
    localparam logic [127:0] C3 = {16{8'h5a}};

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'd16, 1'b0, G1, C1, 8'd255, 1'b0},
        '{5'd8,  1'b0, G1, C1, 8'd255, 1'b0},
        '{5'd12, 1'b0, G2, C2, 8'd255, 1'b0},
        '{5'd16, 1'b1, G1, C1, 8'd255, 1'b0},
        '{5'd16, 1'b1, G2, C2, 8'd15,  1'b0},
        '{5'd8,  1'b1, G2, C2, 8'd7,   1'b0},
        '{5'd8,  1'b1, G2, C2, 8'd8,   1'b1},
        '{5'd12, 1'b1, G3, C3, 8'd11,  1'b0},
        '{5'd12, 1'b1, G3, C3, 8'd12,  1'b1},
        '{5'd1,  1'b1, G1, C2, 8'd15,  1'b0},
        '{5'd0,  1'b0, G3, C1, 8'd255, 1'b0},
        '{5'd31, 1'b1, G2, C3, 8'd3,   1'b0},
        '{5'd9,  1'b1, G1, C3, 8'd255, 1'b1}
    };

    function automatic int eff_len(input logic [4:0] s);
        if (s == 5'd8)  return 8;
        if (s == 5'd12) return 12;
        return 16;
    endfunction

    function automatic logic [127:0] exp_tag(input logic [127:0] g, input logic [127:0] c,
                                             input logic [4:0] s);
        logic [127:0] t;
        t = g ^ c;
        for (int k = eff_len(s); k < 16; k++) t[127 - 8*k -: 8] = 8'h00;
        return t;
    endfunction

    function automatic string req_of(input logic [4:0] s);
        if (s == 5'd8)  return "R3";
        if (s == 5'd12) return "R4";
        if (s == 5'd16) return "R2";
        return "R5";
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation; returns with outputs of that operation visible.
    task automatic run_op(input logic [4:0] s, input logic inb, input logic [127:0] g,
                          input logic [127:0] c, input logic [127:0] rx);
        @(negedge clk);
        icv_size_i = s; inbound_i = inb; ghash_i = g; ctr0_enc_i = c; rx_tag_i = rx;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] keep_tag;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {127'd0, tag_valid_o}, 128'd0);
        chk("R1 fail",  {127'd0, auth_fail_o}, 128'd0);
        chk("R1 tag",   tag_o, 128'd0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [127:0] rx, et;
            logic ef;
            int n;
            v  = VECS[i];
            n  = eff_len(v.size);
            et = exp_tag(v.g, v.c, v.size);
            rx = v.g ^ v.c;
            if (v.junk)
                for (int k = n; k < 16; k++) rx[127 - 8*k -: 8] = 8'hA5 ^ 8'(k);
            if (v.flip != 8'd255) rx[127 - 8*int'(v.flip) -: 8] ^= 8'h01;
            ef = v.inb && (v.flip != 8'd255) && (int'(v.flip) < n);
            run_op(v.size, v.inb, v.g, v.c, rx);
            chk(req_of(v.size), tag_o, et);
            chk("R6 valid", {127'd0, tag_valid_o}, 128'd1);
            chk(v.junk ? "R8 fail" : (v.inb ? "R7 fail" : "R9 fail"),
                {127'd0, auth_fail_o}, {127'd0, ef});
            @(negedge clk);
            chk("R6 drop", {127'd0, tag_valid_o}, 128'd0);
        end

        // R9: outbound with a totally wrong received tag
        run_op(5'd16, 1'b0, G2, C2, ~(G2 ^ C2));
        chk("R9 outbound no fail", {127'd0, auth_fail_o}, 128'd0);
        chk("R2 outbound tag", tag_o, G2 ^ C2);

        // R10: input changes without a start leave outputs alone
        keep_tag = tag_o;
        @(negedge clk);
        ghash_i = G3; ctr0_enc_i = C1; icv_size_i = 5'd8; inbound_i = 1'b1; rx_tag_i = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 hold tag", tag_o, keep_tag);
        chk("R10 no valid", {127'd0, tag_valid_o}, 128'd0);

        // R6: back-to-back starts, second carries different inputs
        @(negedge clk);
        icv_size_i = 5'd12; inbound_i = 1'b1; ghash_i = G1; ctr0_enc_i = C1;
        rx_tag_i = exp_tag(G1, C1, 5'd12);
        start_i = 1'b1;
        @(negedge clk);
        chk("R6 b2b first tag", tag_o, exp_tag(G1, C1, 5'd12));
        chk("R7 b2b first pass", {127'd0, auth_fail_o}, 128'd0);
        icv_size_i = 5'd8; ghash_i = G2; ctr0_enc_i = C3; rx_tag_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 b2b valid held", {127'd0, tag_valid_o}, 128'd1);
        chk("R3 b2b second tag", tag_o, exp_tag(G2, C3, 5'd8));
        chk("R7 b2b second fail", {127'd0, auth_fail_o}, 128'd1);
        @(negedge clk);
        chk("R6 b2b drop", {127'd0, tag_valid_o}, 128'd0);

        // R8: size 12, junk only in the last four bytes
        run_op(5'd12, 1'b1, G3, C2, (G3 ^ C2) ^ 128'h0000_0000_0000_0000_0000_0000_ffff_ffff);
        chk("R8 tail ignored", {127'd0, auth_fail_o}, 128'd0);
        // R7: one bit wrong in the last kept byte of size 12 (bits [39:32])
        run_op(5'd12, 1'b1, G3, C2, (G3 ^ C2) ^ 128'h0000_0000_0000_0000_0000_0080_0000_0000);
        chk("R7 edge byte", {127'd0, auth_fail_o}, 128'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule